// File: doc/BRIEF.md
# SMI Interrupt Aggregator

This block gathers interrupt requests from the board's peripherals (parallel port, two UARTs, floppy controller, watchdog, mouse, keyboard, keyboard-controller P1.2 line and an infrared receiver) and folds them into one active-low system management interrupt pin. Firmware works with it through a byte-wide indexed register port. The port has one enable register, two status registers and a spare storage byte.

Every source except the infrared input enters through a two-stage synchronizer. Its status bit follows the synchronized level, so the bit is cleared only when the peripheral drops its request. The infrared input works differently. Any change of level on it latches a sticky status bit, and that bit clears when firmware reads the status register that holds it.

The status bits of the second status register are gated by their matching enable bits and ORed into a group request. A separate master bit decides whether the group request reaches the `nsmi_o` pin. The pin is driven from a flop.

Top module: `smi_aggregator`

## Requirements
- R1: While `rst_main` is high and in the cycle after it, the registers at indices 0xB5, 0xB6 and 0xB7 read 0x00 and `nsmi_o` is 1.
- R2: Index 0xB5 is the enable register. Writable bits: bit0 mouse, bit1 keyboard, bit2 infrared, bit4 P1.2, bit6 master. Bits 3, 5 and 7 ignore writes and read 0.
- R3: Index 0xB6 reads the synchronized level of each source. Bit1 parallel port, bit2 UART 2, bit3 UART 1, bit4 floppy, bit7 watchdog. Bits 0, 5 and 6 read 0.
- R4: Index 0xB7 reads status. Bit0 mouse, bit1 keyboard and bit4 P1.2 follow the source level. Bit2 is the infrared flag. Bits 3, 5, 6 and 7 read 0.
- R5: A rising or a falling change on `ir_rx_i` sets the infrared flag. The flag stays set after the input stops changing.
- R6: A read of index 0xB7 returns the flag and then clears it. Reads of other indices leave the flag unchanged.
- R7: When a detected infrared change lands in the same cycle as a clearing read, the flag is set afterwards.
- R8: `nsmi_o` is 0 exactly when bit6 of 0xB5 is 1 and some bit of 0xB7 is 1 together with its enable bit. The sources of index 0xB6 never drive the pin.
- R9: While bit6 of 0xB5 is 0, `nsmi_o` stays 1 whatever the sources and enables are.
- R10: Writes to indices 0xB6, 0xB7 and to unmapped indices change no readable register and do not change `nsmi_o`.
- R11: Index 0xB8 is a read/write byte. Only `rst_stby` resets it, and it keeps its value through `rst_main`.
- R12: Read data is valid in the cycle after the read strobe. A source change sampled at clock edge k shows on `nsmi_o` after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_main | input | 1 | Synchronous active-high reset of the main supply domain |
| rst_stby | input | 1 | Synchronous active-high reset of the spare byte |
| addr_i | input | 8 | Register index |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| par_irq_i | input | 1 | Parallel port request |
| uart2_irq_i | input | 1 | UART 2 request |
| uart1_irq_i | input | 1 | UART 1 request |
| fdc_irq_i | input | 1 | Floppy controller request |
| wdt_irq_i | input | 1 | Watchdog request |
| mouse_irq_i | input | 1 | Mouse request |
| kbd_irq_i | input | 1 | Keyboard request |
| p12_irq_i | input | 1 | Keyboard-controller P1.2 line |
| ir_rx_i | input | 1 | Selected infrared receive line |
| nsmi_o | output | 1 | Active-low system management interrupt |

## Verification
The case that is hardest to reach is an infrared change whose detection falls in the same cycle as the clearing read of index 0xB7.

A change on `ir_rx_i` passes two synchronizer stages before the change is detected. The bench therefore counts clock cycles from the falling edge on which it toggles the input. It then issues the read so that the read strobe is sampled at exactly the third following rising edge.

That read must return the flag as clear. The next read must return it as set. Separate reads of the other indices confirm that only index 0xB7 clears the flag.

// File: rtl/smi_agg_pkg.sv
package smi_agg_pkg;
  localparam int unsigned BUS_W = 8;

  localparam logic [BUS_W-1:0] IDX_ENABLE = 8'hB5;
  localparam logic [BUS_W-1:0] IDX_STAT_A = 8'hB6;
  localparam logic [BUS_W-1:0] IDX_STAT_B = 8'hB7;
  localparam logic [BUS_W-1:0] IDX_SPARE  = 8'hB8;

  // enable register bit positions
  localparam int unsigned EN_MOUSE  = 0;
  localparam int unsigned EN_KBD    = 1;
  localparam int unsigned EN_IR     = 2;
  localparam int unsigned EN_P12    = 4;
  localparam int unsigned EN_MASTER = 6;

  localparam logic [BUS_W-1:0] EN_WMASK =
    (BUS_W'(1) << EN_MOUSE) | (BUS_W'(1) << EN_KBD) | (BUS_W'(1) << EN_IR) |
    (BUS_W'(1) << EN_P12)   | (BUS_W'(1) << EN_MASTER);

  // source bits that may feed the group request (status B layout)
  localparam logic [BUS_W-1:0] GRP_MASK =
    (BUS_W'(1) << EN_MOUSE) | (BUS_W'(1) << EN_KBD) | (BUS_W'(1) << EN_IR) |
    (BUS_W'(1) << EN_P12);

  // level-source vector ordering inside the synchronizer
  localparam int unsigned LV_PAR   = 0;
  localparam int unsigned LV_U2    = 1;
  localparam int unsigned LV_U1    = 2;
  localparam int unsigned LV_FDC   = 3;
  localparam int unsigned LV_WDT   = 4;
  localparam int unsigned LV_MOUSE = 5;
  localparam int unsigned LV_KBD   = 6;
  localparam int unsigned LV_P12   = 7;
  localparam int unsigned LV_N     = 8;
endpackage

// File: rtl/smi_sync.sv
module smi_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/smi_edge_latch.sv
module smi_edge_latch #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic clr_i,
  output logic flag_o
);
  logic pin_s;
  logic pin_d;
  logic chg;

  smi_sync #(.WIDTH(1), .STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (pin_s)
  );

  always_ff @(posedge clk) begin
    if (rst) pin_d <= 1'b0;
    else     pin_d <= pin_s;
  end

  assign chg = pin_s ^ pin_d;

  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= chg | (flag_o & ~clr_i);
  end

  // R5
  ir_set_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_s != pin_d) |=> flag_o);
  // R6
  ir_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && (pin_s == pin_d)) |=> !flag_o);
  // R7
  ir_collide_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && (pin_s != pin_d)) |=> flag_o);
endmodule

// File: rtl/smi_regfile.sv
module smi_regfile
  import smi_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_main,
  input  logic             rst_stby,
  input  logic [BUS_W-1:0] addr_i,
  input  logic             wr_en_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             rd_en_i,
  input  logic [BUS_W-1:0] stat_a_i,
  input  logic [BUS_W-1:0] stat_b_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic [BUS_W-1:0] enable_o,
  output logic             clr_b_o
);
  logic [BUS_W-1:0] en_q;
  logic [BUS_W-1:0] spare_q;
  logic [BUS_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst_main)                               en_q <= '0;
    else if (wr_en_i && addr_i == IDX_ENABLE)   en_q <= wdata_i & EN_WMASK;
  end

  always_ff @(posedge clk) begin
    if (rst_stby)                               spare_q <= '0;
    else if (wr_en_i && addr_i == IDX_SPARE)    spare_q <= wdata_i;
  end

  always_comb begin
    unique case (addr_i)
      IDX_ENABLE: rd_mux = en_q;
      IDX_STAT_A: rd_mux = stat_a_i;
      IDX_STAT_B: rd_mux = stat_b_i;
      IDX_SPARE:  rd_mux = spare_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_main)     rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assign clr_b_o  = rd_en_i && (addr_i == IDX_STAT_B);
  assign enable_o = en_q;

  // R10
  en_hold_chk: assert property (@(posedge clk) disable iff (rst_main)
    (!wr_en_i || addr_i != IDX_ENABLE) |=> $stable(en_q));
  // R11
  spare_keep_chk: assert property (@(posedge clk) disable iff (rst_stby)
    (rst_main && !(wr_en_i && addr_i == IDX_SPARE)) |=> $stable(spare_q));
endmodule

// File: rtl/smi_aggregator.sv
module smi_aggregator
  import smi_agg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_main,
  input  logic             rst_stby,
  input  logic [BUS_W-1:0] addr_i,
  input  logic             wr_en_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             rd_en_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic             par_irq_i,
  input  logic             uart2_irq_i,
  input  logic             uart1_irq_i,
  input  logic             fdc_irq_i,
  input  logic             wdt_irq_i,
  input  logic             mouse_irq_i,
  input  logic             kbd_irq_i,
  input  logic             p12_irq_i,
  input  logic             ir_rx_i,
  output logic             nsmi_o
);
  logic [LV_N-1:0]  lv_raw;
  logic [LV_N-1:0]  lv_s;
  logic             ir_flag;
  logic             clr_b;
  logic [BUS_W-1:0] stat_a;
  logic [BUS_W-1:0] stat_b;
  logic [BUS_W-1:0] en;
  logic             group_req;
  logic             nsmi_q;

  always_comb begin
    lv_raw           = '0;
    lv_raw[LV_PAR]   = par_irq_i;
    lv_raw[LV_U2]    = uart2_irq_i;
    lv_raw[LV_U1]    = uart1_irq_i;
    lv_raw[LV_FDC]   = fdc_irq_i;
    lv_raw[LV_WDT]   = wdt_irq_i;
    lv_raw[LV_MOUSE] = mouse_irq_i;
    lv_raw[LV_KBD]   = kbd_irq_i;
    lv_raw[LV_P12]   = p12_irq_i;
  end

  smi_sync #(.WIDTH(LV_N), .STAGES(SYNC_STAGES)) u_lvl_sync (
    .clk (clk),
    .rst (rst_main),
    .d_i (lv_raw),
    .q_o (lv_s)
  );

  smi_edge_latch #(.STAGES(SYNC_STAGES)) u_ir (
    .clk    (clk),
    .rst    (rst_main),
    .pin_i  (ir_rx_i),
    .clr_i  (clr_b),
    .flag_o (ir_flag)
  );

  always_comb begin
    stat_a    = '0;
    stat_a[1] = lv_s[LV_PAR];
    stat_a[2] = lv_s[LV_U2];
    stat_a[3] = lv_s[LV_U1];
    stat_a[4] = lv_s[LV_FDC];
    stat_a[7] = lv_s[LV_WDT];
  end

  always_comb begin
    stat_b          = '0;
    stat_b[EN_MOUSE] = lv_s[LV_MOUSE];
    stat_b[EN_KBD]   = lv_s[LV_KBD];
    stat_b[EN_IR]    = ir_flag;
    stat_b[EN_P12]   = lv_s[LV_P12];
  end

  smi_regfile u_regs (
    .clk      (clk),
    .rst_main (rst_main),
    .rst_stby (rst_stby),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wdata_i  (wdata_i),
    .rd_en_i  (rd_en_i),
    .stat_a_i (stat_a),
    .stat_b_i (stat_b),
    .rdata_o  (rdata_o),
    .enable_o (en),
    .clr_b_o  (clr_b)
  );

  assign group_req = |(stat_b & en & GRP_MASK);

  always_ff @(posedge clk) begin
    if (rst_main) nsmi_q <= 1'b1;
    else          nsmi_q <= ~(group_req & en[EN_MASTER]);
  end

  assign nsmi_o = nsmi_q;

  // R9
  master_gate_chk: assert property (@(posedge clk) disable iff (rst_main)
    !en[EN_MASTER] |=> nsmi_o);
  // R8
  group_drive_chk: assert property (@(posedge clk) disable iff (rst_main)
    (en[EN_MASTER] && (ir_flag && en[EN_IR])) |=> !nsmi_o);
  // R8
  idle_pin_chk: assert property (@(posedge clk) disable iff (rst_main)
    ((stat_b & en) == '0) |=> nsmi_o);
endmodule

// File: tb/smi_aggregator_tb.sv
`timescale 1ns/1ps
module smi_aggregator_tb;
  logic       clk = 1'b0;
  logic       rst_main = 1'b1;
  logic       rst_stby = 1'b1;
  logic [7:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic       par = 0, u2 = 0, u1 = 0, fdc = 0, wdt = 0;
  logic       mouse = 0, kbd = 0, p12 = 0, ir = 0;
  logic       nsmi;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  smi_aggregator u_dut (
    .clk (clk), .rst_main (rst_main), .rst_stby (rst_stby),
    .addr_i (addr), .wr_en_i (wr_en), .wdata_i (wdata),
    .rd_en_i (rd_en), .rdata_o (rdata),
    .par_irq_i (par), .uart2_irq_i (u2), .uart1_irq_i (u1),
    .fdc_irq_i (fdc), .wdt_irq_i (wdt), .mouse_irq_i (mouse),
    .kbd_irq_i (kbd), .p12_irq_i (p12), .ir_rx_i (ir), .nsmi_o (nsmi)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 nsmi in reset", {7'b0, nsmi}, 8'h01);
    rst_main = 1'b0; rst_stby = 1'b0;
    @(negedge clk);
    chk("R1 nsmi after reset", {7'b0, nsmi}, 8'h01);
    rd(8'hB5, v); chk("R1 enable reset", v, 8'h00);
    rd(8'hB6, v); chk("R1 status A reset", v, 8'h00);
    rd(8'hB7, v); chk("R1 status B reset", v, 8'h00);
  endtask

  task automatic t_enable();
    logic [7:0] v;
    wr(8'hB5, 8'hFF); rd(8'hB5, v); chk("R2 enable all ones", v, 8'h57);
    wr(8'hB5, 8'hA8); rd(8'hB5, v); chk("R2 reserved only", v, 8'h00);
    wr(8'hB5, 8'h12); rd(8'hB5, v); chk("R2 kbd+p12", v, 8'h12);
    wr(8'hB5, 8'h00);
  endtask

  task automatic t_status_a();
    logic [7:0] v;
    wr(8'hB5, 8'hFF);
    par = 1; settle(); rd(8'hB6, v); chk("R3 parallel", v, 8'h02);
    par = 0; u2 = 1; settle(); rd(8'hB6, v); chk("R3 uart2", v, 8'h04);
    u2 = 0; u1 = 1; fdc = 1; settle(); rd(8'hB6, v); chk("R3 uart1+fdc", v, 8'h18);
    u1 = 0; fdc = 0; wdt = 1; settle(); rd(8'hB6, v); chk("R3 watchdog", v, 8'h80);
    par = 1; u2 = 1; u1 = 1; fdc = 1; settle();
    rd(8'hB6, v); chk("R3 all", v, 8'h9E);
    chk("R8 status A ignored by pin", {7'b0, nsmi}, 8'h01);
    par = 0; u2 = 0; u1 = 0; fdc = 0; wdt = 0; settle();
    rd(8'hB6, v); chk("R3 released", v, 8'h00);
    wr(8'hB5, 8'h00);
  endtask

  task automatic t_status_b();
    logic [7:0] v;
    mouse = 1; settle(); rd(8'hB7, v); chk("R4 mouse", v, 8'h01);
    mouse = 0; kbd = 1; p12 = 1; settle(); rd(8'hB7, v); chk("R4 kbd+p12", v, 8'h12);
    kbd = 0; p12 = 0; settle(); rd(8'hB7, v); chk("R4 released", v, 8'h00);
  endtask

  task automatic t_ir();
    logic [7:0] v;
    ir = 1; settle(); settle();
    rd(8'hB7, v); chk("R5 rise sets flag", v, 8'h04);
    rd(8'hB7, v); chk("R6 cleared by read", v, 8'h00);
    ir = 0; settle();
    rd(8'hB6, v); rd(8'hB5, v); rd(8'hB8, v);
    rd(8'hB7, v); chk("R6 other reads keep flag / R5 fall", v, 8'h04);
    rd(8'hB7, v); chk("R6 cleared again", v, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    ir = 1;
    @(negedge clk); @(negedge clk);
    rd(8'hB7, v); chk("R7 read at collision", v, 8'h00);
    rd(8'hB7, v); chk("R7 flag survives", v, 8'h04);
    rd(8'hB7, v); chk("R7 then clears", v, 8'h00);
    ir = 0; settle(); rd(8'hB7, v);
  endtask

  task automatic t_group();
    logic [7:0] v;
    wr(8'hB5, 8'h41);
    mouse = 1;
    @(negedge clk); @(negedge clk);
    chk("R12 pin not yet", {7'b0, nsmi}, 8'h01);
    @(negedge clk);
    chk("R12 pin after third edge", {7'b0, nsmi}, 8'h00);
    mouse = 0; kbd = 1; settle();
    chk("R8 disabled source", {7'b0, nsmi}, 8'h01);
    wr(8'hB5, 8'h42); settle();
    chk("R8 kbd enabled", {7'b0, nsmi}, 8'h00);
    wr(8'hB5, 8'h02); settle();
    chk("R9 master off", {7'b0, nsmi}, 8'h01);
    kbd = 0; ir = 1; settle(); settle();
    chk("R9 master off ir", {7'b0, nsmi}, 8'h01);
    wr(8'hB5, 8'h44); @(negedge clk);
    chk("R8 ir flag drives pin", {7'b0, nsmi}, 8'h00);
    rd(8'hB7, v); @(negedge clk); @(negedge clk);
    chk("R8 pin releases after clear", {7'b0, nsmi}, 8'h01);
    ir = 0; settle(); rd(8'hB7, v);
    wr(8'hB5, 8'h00);
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    wr(8'hB5, 8'h41);
    wr(8'hB6, 8'hFF); wr(8'hB7, 8'hFF); wr(8'h00, 8'hFF); wr(8'hB4, 8'hFF);
    settle();
    rd(8'hB6, v); chk("R10 status A unchanged", v, 8'h00);
    rd(8'hB7, v); chk("R10 status B unchanged", v, 8'h00);
    rd(8'hB5, v); chk("R10 enable unchanged", v, 8'h41);
    chk("R10 pin unchanged", {7'b0, nsmi}, 8'h01);
    wr(8'hB5, 8'h00);
  endtask

  task automatic t_spare();
    logic [7:0] v;
    wr(8'hB8, 8'hA5); rd(8'hB8, v); chk("R11 spare write", v, 8'hA5);
    wr(8'hB5, 8'h17);
    rst_main = 1'b1; @(negedge clk); rst_main = 1'b0; @(negedge clk);
    rd(8'hB8, v); chk("R11 kept through main reset", v, 8'hA5);
    rd(8'hB5, v); chk("R1 enable after main reset", v, 8'h00);
    rst_stby = 1'b1; @(negedge clk); rst_stby = 1'b0; @(negedge clk);
    rd(8'hB8, v); chk("R11 standby reset", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_enable();
    t_status_a();
    t_status_b();
    t_ir();
    t_collide();
    t_group();
    t_ignored();
    t_spare();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule